// File: doc/BRIEF.md
# Stream-to-Burst Read Queue

This block sits between a producer that pushes 256-bit write payload words on a valid/ready stream and a data mover that pulls those words back through a memory-mapped slave with burst reads. Incoming words are queued in arrival order. The slave ignores the read address and always returns the oldest queued words first, so the data mover can address the queue as if it were memory while the block behaves as a plain first-in first-out store.

A burst is only granted once the queue already holds every beat the burst asks for. After that, read data valid stays high for exactly that many consecutive cycles, with no gaps. The producer may keep pushing while a burst drains. The current fill level is exported so that upstream logic can see how much payload is waiting.

Top module: `burst_read_queue`

## Requirements
- R1: A stream word is stored on a rising clock edge where `snk_valid` and `snk_ready` are both high. With no burst beat leaving in that cycle, `fifo_level` rises by one on the next cycle.
- R2: `snk_ready` is high exactly while `fifo_level` is below DEPTH (default 32). A word offered while the queue is full is dropped and never returned.
- R3: Words come out on `mm_rdata` in the order they were stored, whatever value `mm_addr` carries.
- R4: `mm_waitreq` is low only when `mm_cs` is high, no burst is in progress, and `fifo_level` is at least the effective burst length. A request seen with `mm_waitreq` low is accepted on that edge.
- R5: After an accepted request, `mm_rdvalid` is high on exactly the effective-burst-length consecutive cycles that start on the cycle after acceptance. One queued word leaves on each of those cycles.
- R6: While a burst is in progress (`mm_rdvalid` high), `mm_waitreq` stays high, so no new request is accepted.
- R7: A `mm_burst` value of 0 is treated as a one-beat burst. Any other value n (1 to 31) means n beats.
- R8: While `rst_n` is low on a clock edge, the queue is emptied and any burst is cancelled. On the next cycle `fifo_level` is 0, `mm_rdvalid` is 0 and `snk_ready` is 1.
- R9: When a push and a burst beat fall on the same cycle, `fifo_level` is unchanged. In general, `fifo_level` equals the words stored minus the words returned since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| snk_valid | input | 1 | Stream word offered |
| snk_ready | output | 1 | Queue has room for a word |
| snk_data | input | 256 | Stream payload word |
| mm_read | input | 1 | Burst read request strobe |
| mm_addr | input | 64 | Read address, accepted but not used |
| mm_burst | input | 5 | Burst length in beats, 0 means 1 |
| mm_cs | input | 1 | Slave selected |
| mm_waitreq | output | 1 | Request not accepted this cycle |
| mm_rdata | output | 256 | Returned payload word |
| mm_rdvalid | output | 1 | `mm_rdata` carries a burst beat |
| fifo_level | output | 6 | Number of queued words |

## Verification
The bench sweeps every burst length from 0 to 31. For each length it parks the queue one word short and checks that the request is held off. It also checks that dropping chip select holds the request off, even with enough data queued. A design that compared the level with the raw count would mishandle length 0, and one that granted on a level check taken before the last push would emit a gap or a stale word. Pushes land during bursts, so a design that lost a level update on simultaneous push and pop would drift. A push is attempted into a full queue, which would corrupt later data if it were not dropped. Finally, a reset is applied in the middle of a burst to catch a beat counter that survives reset and keeps popping.

// File: rtl/brq_pkg.sv
package brq_pkg;

    // Default geometry shared by the queue, its controller and the bench.
    parameter int unsigned BRQ_DATA_W = 256;
    parameter int unsigned BRQ_DEPTH  = 32;
    parameter int unsigned BRQ_BCNT_W = 5;
    parameter int unsigned BRQ_ADDR_W = 64;

    // Burst controller phases.
    typedef enum logic {
        BRQ_IDLE   = 1'b0,
        BRQ_STREAM = 1'b1
    } brq_phase_e;

endpackage

// File: rtl/brq_store.sv
// brq_store: first-in first-out word store with an occupancy count.
// Assumes: pop is only raised while level is non-zero; a push while
// full is ignored. Reads are combinational from the head entry.
module brq_store #(
    parameter int unsigned DATA_W = brq_pkg::BRQ_DATA_W,
    parameter int unsigned DEPTH  = brq_pkg::BRQ_DEPTH,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output logic [LVL_W-1:0]  level,
    output logic              full
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [PTR_W-1:0]  wr_nxt, rd_nxt;
    logic              do_push;

    assign full    = (level == LVL_W'(DEPTH));
    assign do_push = push && !full;

    // Pointer advance: plain wrap for power-of-two depth, compare otherwise.
    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            assign wr_nxt = wr_ptr + PTR_W'(1);
            assign rd_nxt = rd_ptr + PTR_W'(1);
        end else begin : g_mod
            assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
            assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
        end
    endgenerate

    // Storage write: the entry at the write pointer takes the pushed word.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Pointer and occupancy bookkeeping, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= wr_nxt;
            end
            if (pop) begin
                rd_ptr <= rd_nxt;
            end
            case ({do_push, pop})
                2'b10:   level <= level + LVL_W'(1);
                2'b01:   level <= level - LVL_W'(1);
                default: level <= level;
            endcase
        end
    end

    assign head_data = mem[rd_ptr];

endmodule

// File: rtl/brq_burst_ctl.sv
// brq_burst_ctl: grants a burst read only when the queue already holds
// every beat, then streams one beat per cycle until the burst is done.
// Assumes: the master holds its request while waitreq is high.
module brq_burst_ctl #(
    parameter int unsigned BCNT_W = brq_pkg::BRQ_BCNT_W,
    parameter int unsigned LVL_W  = 6,
    localparam int unsigned CMP_W = (LVL_W > BCNT_W) ? LVL_W : BCNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              cs,
    input  logic [BCNT_W-1:0] bcnt,
    input  logic [LVL_W-1:0]  level,
    output logic              waitreq,
    output logic              pop,
    output logic              rdvalid
);
    import brq_pkg::*;

    brq_phase_e        phase;
    logic [BCNT_W-1:0] remain;
    logic [BCNT_W-1:0] eff_len;
    logic              enough;
    logic              accept;

    // Effective length: a zero count means a single beat.
    always_comb begin
        eff_len = (bcnt == '0) ? BCNT_W'(1) : bcnt;
    end

    // Grant condition: selected, idle and the full burst already queued.
    always_comb begin
        enough  = (CMP_W'(level) >= CMP_W'(eff_len));
        waitreq = !(cs && (phase == BRQ_IDLE) && enough);
        accept  = rd && !waitreq;
    end

    // Beat sequencer: loads the length on grant, counts down one per beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= BRQ_IDLE;
            remain <= '0;
        end else begin
            case (phase)
                BRQ_IDLE: begin
                    if (accept) begin
                        phase  <= BRQ_STREAM;
                        remain <= eff_len;
                    end
                end
                BRQ_STREAM: begin
                    if (remain == BCNT_W'(1)) begin
                        phase  <= BRQ_IDLE;
                        remain <= '0;
                    end else begin
                        remain <= remain - BCNT_W'(1);
                    end
                end
                default: begin
                    phase  <= BRQ_IDLE;
                    remain <= '0;
                end
            endcase
        end
    end

    assign rdvalid = (phase == BRQ_STREAM);
    assign pop     = rdvalid;

endmodule

// File: rtl/burst_read_queue.sv
// burst_read_queue: stream sink feeding a queue that a data mover drains
// with address-ignoring memory-mapped burst reads.
// Assumes: a burst longer than DEPTH is never issued (it would never be
// granted); the address carries no meaning for the returned data.
module burst_read_queue #(
    parameter int unsigned DATA_W = brq_pkg::BRQ_DATA_W,
    parameter int unsigned DEPTH  = brq_pkg::BRQ_DEPTH,
    parameter int unsigned BCNT_W = brq_pkg::BRQ_BCNT_W,
    parameter int unsigned ADDR_W = brq_pkg::BRQ_ADDR_W,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snk_valid,
    output logic              snk_ready,
    input  logic [DATA_W-1:0] snk_data,
    input  logic              mm_read,
    input  logic [ADDR_W-1:0] mm_addr,
    input  logic [BCNT_W-1:0] mm_burst,
    input  logic              mm_cs,
    output logic              mm_waitreq,
    output logic [DATA_W-1:0] mm_rdata,
    output logic              mm_rdvalid,
    output logic [LVL_W-1:0]  fifo_level
);

    logic q_full;
    logic q_pop;
    logic q_push;
    logic addr_unused;

    // The address is deliberately discarded: data leaves in queue order.
    assign addr_unused = ^mm_addr;

    assign snk_ready = !q_full;
    assign q_push    = snk_valid && snk_ready;

    brq_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data (snk_data),
        .pop       (q_pop),
        .head_data (mm_rdata),
        .level     (fifo_level),
        .full      (q_full)
    );

    brq_burst_ctl #(
        .BCNT_W (BCNT_W),
        .LVL_W  (LVL_W)
    ) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (mm_read),
        .cs      (mm_cs),
        .bcnt    (mm_burst),
        .level   (fifo_level),
        .waitreq (mm_waitreq),
        .pop     (q_pop),
        .rdvalid (mm_rdvalid)
    );

endmodule

// File: rtl/brq_checker.sv
// brq_checker: protocol and occupancy properties of burst_read_queue,
// observed only at its ports. Tracks the expected beats of each burst.
module brq_checker #(
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned BCNT_W = 5,
    parameter int unsigned LVL_W  = 6,
    localparam int unsigned CMP_W = (LVL_W > BCNT_W) ? LVL_W : BCNT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              snk_valid,
    input logic              snk_ready,
    input logic              mm_read,
    input logic              mm_cs,
    input logic [BCNT_W-1:0] mm_burst,
    input logic              mm_waitreq,
    input logic              mm_rdvalid,
    input logic [LVL_W-1:0]  fifo_level
);

    logic [BCNT_W-1:0] want;
    logic [BCNT_W-1:0] owed;

    assign want = (mm_burst == '0) ? BCNT_W'(1) : mm_burst;

    // Beats still owed for the granted burst, independent of the design.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed <= '0;
        end else if (mm_read && !mm_waitreq) begin
            owed <= want;
        end else if (owed != '0) begin
            owed <= owed - BCNT_W'(1);
        end
    end

    a_r1_push_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (snk_valid && snk_ready && !mm_rdvalid) |=> (fifo_level == $past(fifo_level) + LVL_W'(1)));

    a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level == LVL_W'(DEPTH)) |-> !snk_ready);

    a_r2_room_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level < LVL_W'(DEPTH)) |-> snk_ready);

    a_r4_grant_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_read && !mm_waitreq) |-> (mm_cs && (CMP_W'(fifo_level) >= CMP_W'(want))));

    a_r5_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (owed != '0) |-> mm_rdvalid);

    a_r5_no_extra: assert property (@(posedge clk) disable iff (!rst_n)
        mm_rdvalid |-> (owed != '0));

    a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        mm_rdvalid |-> mm_waitreq);

    a_r8_reset_clears: assert property (@(posedge clk)
        !rst_n |=> ((fifo_level == '0) && !mm_rdvalid));

    a_r9_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        CMP_W'(fifo_level) <= CMP_W'(DEPTH));

endmodule

bind burst_read_queue brq_checker #(
    .DEPTH  (DEPTH),
    .BCNT_W (BCNT_W),
    .LVL_W  (LVL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .snk_valid  (snk_valid),
    .snk_ready  (snk_ready),
    .mm_read    (mm_read),
    .mm_cs      (mm_cs),
    .mm_burst   (mm_burst),
    .mm_waitreq (mm_waitreq),
    .mm_rdvalid (mm_rdvalid),
    .fifo_level (fifo_level)
);

// File: tb/burst_read_queue_test.sv
module burst_read_queue_test;

    localparam int DEPTH = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         snk_valid = 1'b0;
    logic         snk_ready;
    logic [255:0] snk_data = '0;
    logic         mm_read = 1'b0;
    logic [63:0]  mm_addr = '0;
    logic [4:0]   mm_burst = '0;
    logic         mm_cs = 1'b0;
    logic         mm_waitreq;
    logic [255:0] mm_rdata;
    logic         mm_rdvalid;
    logic [5:0]   fifo_level;

    int errors = 0;
    int checks = 0;
    int pidx = 0;
    int qidx = 0;
    int lvl = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    burst_read_queue uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .snk_valid  (snk_valid),
        .snk_ready  (snk_ready),
        .snk_data   (snk_data),
        .mm_read    (mm_read),
        .mm_addr    (mm_addr),
        .mm_burst   (mm_burst),
        .mm_cs      (mm_cs),
        .mm_waitreq (mm_waitreq),
        .mm_rdata   (mm_rdata),
        .mm_rdvalid (mm_rdvalid),
        .fifo_level (fifo_level)
    );

    function automatic logic [255:0] pat(int k);
        logic [255:0] r;
        for (int lane = 0; lane < 8; lane++) begin
            r[lane*32 +: 32] = 32'(k) * 32'h0100_0193 + 32'(lane) * 32'h9E37_79B1 + 32'h5A5A;
        end
        return r;
    endfunction

    task automatic chk_int(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_data(string req, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Offer one word; called just after a falling edge, returns after the next.
    task automatic push_one();
        bit rdy;
        snk_valid = 1'b1;
        snk_data  = pat(pidx);
        #1;
        chk_int("R2 ready while room", int'(snk_ready), int'(lvl < DEPTH));
        rdy = snk_ready;
        @(posedge clk);
        if (rdy) begin
            pidx++;
            lvl++;
        end
        @(negedge clk);
        snk_valid = 1'b0;
        chk_int("R1 level after push", int'(fifo_level), lvl);
    endtask

    // Request that must be held off for one cycle.
    task automatic expect_stall(bit cs, int b, string req);
        mm_read  = 1'b1;
        mm_cs    = cs;
        mm_burst = 5'(b);
        mm_addr  = 64'hDEAD_0000 + 64'(b);
        #1;
        chk_int(req, int'(mm_waitreq), 1);
        @(posedge clk);
        @(negedge clk);
        mm_read = 1'b0;
        mm_cs   = 1'b0;
        #1;
        chk_int("R4 nothing streamed after stall", int'(mm_rdvalid), 0);
        chk_int("R4 level kept after stall", int'(fifo_level), lvl);
    endtask

    // Granted burst, pushing during its first extra beats.
    task automatic do_burst(int b, int extra, logic [63:0] addr);
        int eff;
        bit rdy;
        bit pv;
        eff = (b == 0) ? 1 : b;
        mm_read  = 1'b1;
        mm_cs    = 1'b1;
        mm_burst = 5'(b);
        mm_addr  = addr;
        #1;
        chk_int((b == 0) ? "R7 zero count granted" : "R4 grant with data", int'(mm_waitreq), 0);
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < eff; i++) begin
            pv        = (i < extra);
            snk_valid = pv;
            snk_data  = pat(pidx);
            #1;
            chk_int("R5 beat valid", int'(mm_rdvalid), 1);
            chk_data("R3 order ignores address", mm_rdata, pat(qidx));
            chk_int("R6 busy blocks request", int'(mm_waitreq), 1);
            if (pv) chk_int("R2 ready during burst", int'(snk_ready), int'(lvl < DEPTH));
            rdy = snk_ready;
            @(posedge clk);
            qidx++;
            lvl--;
            if (pv && rdy) begin
                pidx++;
                lvl++;
            end
            @(negedge clk);
        end
        mm_read   = 1'b0;
        mm_cs     = 1'b0;
        snk_valid = 1'b0;
        #1;
        chk_int((b == 0) ? "R7 single beat only" : "R5 burst ends on count", int'(mm_rdvalid), 0);
        chk_int("R9 level after burst", int'(fifo_level), lvl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R5 watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk_int("R8 reset level", int'(fifo_level), 0);
        chk_int("R8 reset rdvalid", int'(mm_rdvalid), 0);
        chk_int("R8 reset ready", int'(snk_ready), 1);

        // Sweep every burst count, including zero.
        for (int b = 0; b < 32; b++) begin
            int eff;
            eff = (b == 0) ? 1 : b;
            while (lvl < eff - 1) push_one();
            if (lvl == eff - 1) begin
                expect_stall(1'b1, b, (b == 0) ? "R7 zero count needs a word" : "R4 short of data");
            end
            while (lvl < eff) push_one();
            expect_stall(1'b0, b, "R4 chip select low");
            do_burst(b, b % 3, 64'(b) * 64'h1000 + 64'd7);
        end

        // Fill completely, offer a word that must be dropped.
        while (lvl < DEPTH) push_one();
        snk_valid = 1'b1;
        snk_data  = ~pat(pidx);
        #1;
        chk_int("R2 full not ready", int'(snk_ready), 0);
        @(posedge clk);
        @(negedge clk);
        snk_valid = 1'b0;
        chk_int("R2 level held when full", int'(fifo_level), DEPTH);
        do_burst(31, 0, 64'h0);
        do_burst(1, 0, 64'hFFFF_FFFF_FFFF_FFF8);
        chk_int("R9 drained", int'(fifo_level), 0);

        // Reset in the middle of a burst.
        for (int k = 0; k < 5; k++) push_one();
        mm_read  = 1'b1;
        mm_cs    = 1'b1;
        mm_burst = 5'd4;
        #1;
        chk_int("R4 grant before reset", int'(mm_waitreq), 0);
        @(posedge clk);
        @(negedge clk);
        mm_read = 1'b0;
        mm_cs   = 1'b0;
        #1;
        chk_int("R5 burst running", int'(mm_rdvalid), 1);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        lvl   = 0;
        qidx  = pidx;
        #1;
        chk_int("R8 burst cancelled", int'(mm_rdvalid), 0);
        chk_int("R8 queue emptied", int'(fifo_level), 0);
        chk_int("R8 ready after reset", int'(snk_ready), 1);
        @(posedge clk);
        @(negedge clk);
        chk_int("R8 no leftover beats", int'(mm_rdvalid), 0);
        push_one();
        push_one();
        do_burst(2, 0, 64'h40);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule